// File: doc/BRIEF.md
# SAR ADC conversion-readout sequencer

This block runs a successive-approximation converter over a serial link. A one-cycle start request sets off one sequence. The block starts a conversion and waits out the worst-case conversion time. It then clocks the result in over a serial clock and presents it as a sign- or zero-extended parallel word, with a one-cycle done strobe. Two ways of wiring the converter are supported, picked per sequence by a mode input:

- **Dedicated-strobe option:** a separate convert line stays high from the start of the sequence to the end of the readout.
- **Shared-select option:** the active-low select is first held low for a quiet time. It then goes high, and that rising edge starts the conversion. The convert line is never used in this option.

All times are turned into system-clock cycles with a ceiling, so each minimum time is always met. Mode, turbo and width are captured when a start request is accepted. The state machine has four states:

- `ST_IDLE`: waits for a start request.
- `ST_QUIET`: select low before the convert edge. Used in the shared-select option only.
- `ST_CONVERT`: select high for the conversion time.
- `ST_READ`: select low while the serial clock runs.

The state machine has five transitions:

- `ST_IDLE` to `ST_QUIET` on an accepted start in the shared-select option.
- `ST_IDLE` to `ST_CONVERT` on an accepted start in the dedicated-strobe option.
- `ST_QUIET` to `ST_CONVERT` when the quiet timer expires.
- `ST_CONVERT` to `ST_READ` when the conversion timer expires.
- `ST_READ` to `ST_IDLE` on the falling serial-clock edge that follows the last bit.

Top module: `sar_readout_seq`

## Requirements
- R1: While reset is applied and right after it, cs_n_o is 1, cnv_o is 0, sclk_o is 0, done_o is 0 and sample_o is 0.
- R2: With shared_sel_i = 0 at start, cnv_o goes high in the cycle after the accepted start. It stays high through the whole conversion and readout, so it is high for exactly the conversion cycles plus the readout cycles. It returns low in the cycle in which done_o is high. Through the conversion cs_n_o is 1; through the readout it is 0.
- R3: With shared_sel_i = 1 at start, cnv_o stays 0 for the whole sequence. cs_n_o goes low for ceil(QUIET_NS*1000/CLK_PERIOD_PS) cycles (5 at the defaults) and then goes high.
- R4: cs_n_o stays high for ceil(t*1000/CLK_PERIOD_PS) cycles before the readout. Here t is CONV_NS when turbo_i = 0 at start (105 cycles at the defaults) and TURBO_CONV_NS when turbo_i = 1 (80 cycles).
- R5: The readout lasts 2*SCLK_HALF*W cycles with cs_n_o low and gives exactly W rising edges on sclk_o, where W is the selected width. sclk_o is low whenever cs_n_o is high.
- R6: width_sel_i at start selects the width: 00 gives 14 bits, 01 gives 16 bits, and 10 or 11 give 18 bits. Bits arrive MSB first and are sampled on the rising edge of sclk_o. An 18-bit result is two's complement and is sign-extended from bit 17 to 32 bits. A 14- or 16-bit result is zero-extended.
- R7: done_o is high for exactly one cycle per sequence, in the cycle in which cs_n_o returns high. sample_o takes the new value in that cycle and does not change at any other time.
- R8: A start request that arrives while a sequence is running is ignored. Changes to shared_sel_i, turbo_i or width_sel_i during a sequence have no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, one cycle |
| shared_sel_i | input | 1 | 1: select doubles as convert strobe; 0: dedicated convert line |
| turbo_i | input | 1 | Use the shorter turbo conversion time |
| width_sel_i | input | 2 | Result width: 00 = 14, 01 = 16, 10/11 = 18 (signed) |
| sdi_i | input | 1 | Serial data from the converter |
| cnv_o | output | 1 | Dedicated convert line |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles low |
| sample_o | output | OUT_W | Extended conversion result |
| done_o | output | 1 | One-cycle strobe: sample_o is valid |

## Verification
The bench sweeps every combination of wiring option, turbo setting and width code, including the reserved code, with several bit patterns. For each run it counts the cycles of each select phase, the serial clock edges and the cycles in which the convert line is high.

An off-by-one in the ceiling conversion shows up as a short quiet or conversion phase. A wrong shift count shows up as the wrong number of clock edges and a misaligned sample. A sign-extension fault shows up on the patterns with only the top bit set and with all bits set, where the 18-bit result must be negative and the narrower results must not be. A further pass fires a second start request and toggles every configuration input partway through a conversion. A design that restarts, or that reads its configuration live, then produces a second done strobe or different phase lengths.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_QUIET,
        ST_CONVERT,
        ST_READ
    } seq_state_t;

    // Minimum time in ns to a cycle count, rounded up.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        return (ns * 1000 + period_ps - 1) / period_ps;
    endfunction

    // Width code to result width in bits.
    function automatic logic [4:0] width_of(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return 5'd14;
            2'b01:   return 5'd16;
            default: return 5'd18;
        endcase
    endfunction

endpackage

// File: rtl/sar_seq_timer.sv
module sar_seq_timer #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [TMR_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [TMR_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sar_seq_shifter.sv
module sar_seq_shifter #(
    parameter int MAX_BITS  = 18,
    parameter int SCLK_HALF = 2,
    parameter int CNT_W     = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_i,
    input  logic [CNT_W-1:0]    nbits_i,
    input  logic                sdi_i,
    output logic                sclk_o,
    output logic [MAX_BITS-1:0] data_o,
    output logic                last_o
);

    localparam int PH_W = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SCLK_HALF - 1);

    logic [PH_W-1:0]     phase_q;
    logic                sclk_q;
    logic [CNT_W-1:0]    bits_q;
    logic [MAX_BITS-1:0] shreg_q;
    logic                toggle;

    assign toggle = run_i && (phase_q == PH_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            sclk_q  <= 1'b0;
            bits_q  <= '0;
            shreg_q <= '0;
        end else if (!run_i) begin
            phase_q <= '0;
            sclk_q  <= 1'b0;
            bits_q  <= '0;
        end else begin
            phase_q <= toggle ? '0 : phase_q + 1'b1;
            if (toggle) begin
                sclk_q <= ~sclk_q;
                if (!sclk_q) begin
                    shreg_q <= {shreg_q[MAX_BITS-2:0], sdi_i};
                    bits_q  <= bits_q + 1'b1;
                end
            end
        end
    end

    assign sclk_o = sclk_q;
    assign data_o = shreg_q;
    assign last_o = toggle && sclk_q && (bits_q == nbits_i);

endmodule

// File: rtl/sar_seq_format.sv
module sar_seq_format #(
    parameter int MAX_BITS = 18,
    parameter int OUT_W    = 32,
    parameter int CNT_W    = 5
) (
    input  logic [MAX_BITS-1:0] data_i,
    input  logic [CNT_W-1:0]    nbits_i,
    input  logic                signed_i,
    output logic [OUT_W-1:0]    sample_o
);

    logic [CNT_W-1:0] top_idx;
    logic             ext;

    assign top_idx = nbits_i - 1'b1;
    assign ext     = signed_i & data_i[top_idx];

    for (genvar i = 0; i < OUT_W; i++) begin : g_bit
        if (i < MAX_BITS) begin : g_in
            assign sample_o[i] = (CNT_W'(i) < nbits_i) ? data_i[i] : ext;
        end else begin : g_ext
            assign sample_o[i] = ext;
        end
    end

endmodule

// File: rtl/sar_readout_seq.sv
module sar_readout_seq
    import sar_seq_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 4000,
    parameter int QUIET_NS      = 20,
    parameter int CONV_NS       = 420,
    parameter int TURBO_CONV_NS = 320,
    parameter int SCLK_HALF     = 2,
    parameter int MAX_BITS      = 18,
    parameter int OUT_W         = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             shared_sel_i,
    input  logic             turbo_i,
    input  logic [1:0]       width_sel_i,
    input  logic             sdi_i,
    output logic             cnv_o,
    output logic             cs_n_o,
    output logic             sclk_o,
    output logic [OUT_W-1:0] sample_o,
    output logic             done_o
);

    localparam int unsigned QUIET_CYC = ns_to_cycles(QUIET_NS, CLK_PERIOD_PS);
    localparam int unsigned CONV_CYC  = ns_to_cycles(CONV_NS, CLK_PERIOD_PS);
    localparam int unsigned TURBO_CYC = ns_to_cycles(TURBO_CONV_NS, CLK_PERIOD_PS);
    localparam int unsigned MAX_CYC   = (CONV_CYC > QUIET_CYC) ? CONV_CYC : QUIET_CYC;
    localparam int TMR_W = $clog2(MAX_CYC + 1);
    localparam int CNT_W = $clog2(MAX_BITS + 1);

    seq_state_t          state_q, state_d;
    logic                mode_q, turbo_q;
    logic [1:0]          wsel_q;
    logic                accept, mode_d, turbo_d;
    logic                tmr_load, tmr_zero;
    logic [TMR_W-1:0]    tmr_val;
    logic [CNT_W-1:0]    nbits;
    logic [MAX_BITS-1:0] raw;
    logic                shift_last;
    logic [OUT_W-1:0]    fmt;
    logic                cs_n_q, cnv_q, done_q;
    logic [OUT_W-1:0]    sample_q;

    assign accept  = (state_q == ST_IDLE) && start_i;
    assign mode_d  = accept ? shared_sel_i : mode_q;
    assign turbo_d = accept ? turbo_i : turbo_q;
    assign nbits   = CNT_W'(width_of(wsel_q));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (start_i) state_d = shared_sel_i ? ST_QUIET : ST_CONVERT;
            ST_QUIET:   if (tmr_zero) state_d = ST_CONVERT;
            ST_CONVERT: if (tmr_zero) state_d = ST_READ;
            ST_READ:    if (shift_last) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
            turbo_q <= 1'b0;
            wsel_q  <= 2'b00;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            turbo_q <= turbo_d;
            if (accept) wsel_q <= width_sel_i;
        end
    end

    // Phase timer: loaded on entry to quiet or conversion
    assign tmr_load = accept || ((state_q == ST_QUIET) && tmr_zero);
    assign tmr_val  = (accept && shared_sel_i) ? TMR_W'(QUIET_CYC - 1) :
                      (turbo_d ? TMR_W'(TURBO_CYC - 1) : TMR_W'(CONV_CYC - 1));

    sar_seq_timer #(.TMR_W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    sar_seq_shifter #(
        .MAX_BITS  (MAX_BITS),
        .SCLK_HALF (SCLK_HALF),
        .CNT_W     (CNT_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (state_q == ST_READ),
        .nbits_i (nbits),
        .sdi_i   (sdi_i),
        .sclk_o  (sclk_o),
        .data_o  (raw),
        .last_o  (shift_last)
    );

    sar_seq_format #(
        .MAX_BITS (MAX_BITS),
        .OUT_W    (OUT_W),
        .CNT_W    (CNT_W)
    ) u_fmt (
        .data_i   (raw),
        .nbits_i  (nbits),
        .signed_i (wsel_q[1]),
        .sample_o (fmt)
    );

    // Registered pin outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n_q   <= 1'b1;
            cnv_q    <= 1'b0;
            done_q   <= 1'b0;
            sample_q <= '0;
        end else begin
            cs_n_q <= !((state_d == ST_QUIET) || (state_d == ST_READ));
            cnv_q  <= !mode_d && ((state_d == ST_CONVERT) || (state_d == ST_READ));
            done_q <= shift_last;
            if (shift_last) sample_q <= fmt;
        end
    end

    assign cs_n_o   = cs_n_q;
    assign cnv_o    = cnv_q;
    assign done_o   = done_q;
    assign sample_o = sample_q;

endmodule

// File: rtl/sar_readout_seq_chk.sv
module sar_readout_seq_chk #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             cnv,
    input logic             sclk,
    input logic             done,
    input logic [OUT_W-1:0] sample,
    input logic             shared_q
);

    // R3: the convert line stays low in the shared-select option
    a_r3_no_cnv_shared: assert property (@(posedge clk) disable iff (!rst_n)
        shared_q |-> !cnv);

    // R2: the convert line only drops at the end of a readout
    a_r2_cnv_falls_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnv) |-> done);

    // R5: the serial clock is low while the select is high
    a_r5_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R7: done lasts one cycle and coincides with the select high
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_sel_high: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cs_n);

    // R7: the sample only changes with done
    a_r7_sample_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(sample));

endmodule

bind sar_readout_seq sar_readout_seq_chk #(.OUT_W(OUT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n_o),
    .cnv      (cnv_o),
    .sclk     (sclk_o),
    .done     (done_o),
    .sample   (sample_o),
    .shared_q (mode_q)
);

// File: tb/sar_readout_seq_bench.sv
`timescale 1ns/1ps
module sar_readout_seq_bench;

    localparam int PERIOD_PS = 4000;
    localparam int HALF      = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        shared = 1'b0;
    logic        turbo = 1'b0;
    logic [1:0]  wsel = 2'b00;
    logic        sdi;
    logic        cnv, cs_n, sclk, done;
    logic [31:0] sample;

    int          checks = 0;
    int          errors = 0;
    int          cur_w = 14;
    logic [17:0] pat = '0;

    always #2 clk = ~clk;

    sar_readout_seq u_sar_readout_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .shared_sel_i (shared),
        .turbo_i      (turbo),
        .width_sel_i  (wsel),
        .sdi_i        (sdi),
        .cnv_o        (cnv),
        .cs_n_o       (cs_n),
        .sclk_o       (sclk),
        .sample_o     (sample),
        .done_o       (done)
    );

    // Converter model: first bit at select low, next bit after each falling sclk
    initial begin
        automatic int  idx = 0;
        automatic logic pc = 1'b1;
        automatic logic ps = 1'b0;
        sdi = 1'b0;
        forever begin
            @(cs_n or sclk);
            if (pc && !cs_n) idx = cur_w - 1;
            else if (ps && !sclk && idx > 0) idx = idx - 1;
            pc = cs_n;
            ps = sclk;
            sdi <= pat[idx];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int cyc_of(input int ns);
        return (ns * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    endfunction

    function automatic int width_for(input logic [1:0] s);
        return (s == 2'b00) ? 14 : (s == 2'b01) ? 16 : 18;
    endfunction

    function automatic logic [31:0] exp_sample(input logic [1:0] s, input logic [17:0] p);
        automatic int w = width_for(s);
        automatic logic [31:0] mask = (32'h1 << w) - 1;
        automatic logic [31:0] v = {14'h0, p} & mask;
        if (w == 18 && v[17]) v = v | ~mask;
        return v;
    endfunction

    task automatic run(input logic sh, input logic tb, input logic [1:0] ws,
                       input logic [17:0] p, input bit disturb);
        automatic int seg = 0, q = 0, c = 0, r = 0, cn = 0, rises = 0, dones = 0;
        automatic int cyc = 0, extra_act = 0;
        automatic logic prev_s = 1'b0;
        automatic logic [31:0] samp = '0, held;
        automatic int w = width_for(ws);
        automatic int exp_c = tb ? cyc_of(320) : cyc_of(420);
        automatic int exp_q = sh ? cyc_of(20) : 0;
        @(negedge clk);
        shared = sh; turbo = tb; wsel = ws; cur_w = w; pat = p;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (seg < 3 && cyc < 2000) begin
            if (seg == 0) begin
                if (!cs_n) q++; else begin seg = 1; c++; end
            end else if (seg == 1) begin
                if (cs_n) c++; else begin seg = 2; r++; end
            end else begin
                if (!cs_n) r++; else seg = 3;
            end
            cn += int'(cnv);
            if (sclk && !prev_s) rises++;
            prev_s = sclk;
            if (done) begin dones++; samp = sample; end
            if (disturb && cyc == 20) begin
                start = 1'b1; shared = ~sh; turbo = ~tb; wsel = ws + 2'd1;
            end
            if (disturb && cyc == 21) start = 1'b0;
            cyc++;
            if (seg < 3) @(negedge clk);
        end
        chk(cyc < 2000, "R5 sequence completes", cyc, 2000);
        chk(q == exp_q, "R3 quiet cycles", q, exp_q);
        chk(c == exp_c, "R4 conversion cycles", c, exp_c);
        chk(r == 2 * HALF * w, "R5 readout cycles", r, 2 * HALF * w);
        chk(rises == w, "R5 sclk rising edges", rises, w);
        chk(cn == (sh ? 0 : exp_c + 2 * HALF * w), "R2 cnv high cycles", cn,
            sh ? 0 : exp_c + 2 * HALF * w);
        chk(dones == 1, "R7 done count", dones, 1);
        chk(samp == exp_sample(ws, p), "R6 sample value", samp, exp_sample(ws, p));
        held = sample;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (done || !cs_n || cnv || sclk) extra_act++;
            if (sample != held) extra_act++;
        end
        chk(extra_act == 0, disturb ? "R8 no restart or reconfig" : "R7 idle after done",
            extra_act, 0);
        shared = sh; turbo = tb; wsel = ws;
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(cs_n == 1'b1 && cnv == 1'b0 && sclk == 1'b0 && done == 1'b0,
            "R1 pins in reset", {cs_n, cnv, sclk, done}, 4'b1000);
        chk(sample == 32'h0, "R1 sample in reset", sample, 32'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cs_n == 1'b1 && cnv == 1'b0 && sclk == 1'b0 && done == 1'b0,
            "R1 pins after reset", {cs_n, cnv, sclk, done}, 4'b1000);

        for (int m = 0; m < 2; m++) begin
            for (int t = 0; t < 2; t++) begin
                for (int s = 0; s < 4; s++) begin
                    for (int k = 0; k < 4; k++) begin
                        automatic int w = width_for(2'(s));
                        automatic logic [17:0] msk = 18'((32'h1 << w) - 1);
                        automatic logic [17:0] p;
                        case (k)
                            0: p = msk;
                            1: p = 18'h1 << (w - 1);
                            2: p = 18'h2AAAA & msk;
                            default: p = 18'h15A53 & msk;
                        endcase
                        run(1'(m), 1'(t), 2'(s), p, 1'b0);
                    end
                end
            end
        end

        // R8: second start and configuration changes during a conversion
        run(1'b0, 1'b0, 2'b10, 18'h20001, 1'b1);
        run(1'b1, 1'b1, 2'b00, 18'h02F0F, 1'b1);
        run(1'b1, 1'b0, 2'b11, 18'h1FFFF, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule